// File: doc/BRIEF.md
# Port-Side Resource Decoder for a Bidirectional FIFO Pair

This block is the control logic for one side of a pair of FIFOs that run in opposite directions. A single 18-bit data bus on this side can reach one of several internal resources. Which one it reaches is set by an active-low select and a 3-bit address. The resources are:

- the write side of the outgoing FIFO;
- the read side of the incoming FIFO;
- a bypass word that passes straight to the far side;
- four 9-bit threshold registers that tune the almost-empty and almost-full levels of both FIFOs.

The block produces single-cycle strobes toward the FIFO storage and keeps the threshold and bypass registers itself. It holds the registered read word and raises the enable for the off-chip tri-state driver. The FIFO storage and the flag comparators sit outside the block. They connect through plain strobe, data and status ports.

An access happens on a rising clock edge when the select is low and the enable is low. The direction input decides whether the access writes the bus value in or loads the output register. Strobes toward the FIFOs are held back when the target FIFO cannot accept the access.

Top module: `port_res_decoder`

## Requirements
- R1: While `sel_n` is 1, no strobe is raised, no register changes and `dq_oe` is 0, whatever the address.
- R2: A write (`sel_n`=0, `en_n`=0, `rd_wr_n`=0) to address 3'b000 raises `ab_wr` in that cycle with `ab_wdata` equal to `dq_in`.
- R3: A read (`sel_n`=0, `en_n`=0, `rd_wr_n`=1) to address 3'b000 raises `ba_rd` in that cycle, and `dq_out` shows `ba_rdata` from the cycle after the edge.
- R4: `ab_wr` is never raised while `ab_full` is 1, and `ba_rd` is never raised while `ba_empty` is 1. A read refused this way leaves `dq_out` unchanged.
- R5: Address 3'b001 reaches the bypass. A write loads `byp_out` with `dq_in`, and a read loads `dq_out` with `byp_in`.
- R6: Addresses 3'b100, 3'b101, 3'b110 and 3'b111 reach, in that order, the outgoing-FIFO almost-empty threshold, the outgoing-FIFO almost-full threshold, the incoming-FIFO almost-empty threshold and the incoming-FIFO almost-full threshold. A write stores `dq_in[8:0]` and discards bits 17:9. A read returns the stored value zero-extended to 18 bits.
- R7: After reset, all four thresholds hold 8, and `dq_out` and `byp_out` are 0.
- R8: Addresses 3'b010 and 3'b011 are reserved. A write to either changes no register, and a read from either loads `dq_out` with 0.
- R9: While `en_n` is 1, no access takes place: no strobe is raised and no register changes.
- R10: `dq_oe` is 1 exactly when `sel_n`=0, `rd_wr_n`=1 and `oe_n`=0. It does not depend on `en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; accesses happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low port select |
| addr | input | 3 | Resource address |
| rd_wr_n | input | 1 | Direction: 1 = read, 0 = write |
| en_n | input | 1 | Active-low access enable |
| oe_n | input | 1 | Active-low output enable for the bus driver |
| dq_in | input | 18 | Bus value driven into the block |
| dq_out | output | 18 | Registered read word |
| dq_oe | output | 1 | Tri-state driver enable for `dq_out` |
| ab_wr | output | 1 | Write strobe to the outgoing FIFO |
| ab_wdata | output | 18 | Write data to the outgoing FIFO |
| ab_full | input | 1 | Outgoing FIFO is full |
| ba_rd | output | 1 | Read strobe to the incoming FIFO |
| ba_rdata | input | 18 | Head word of the incoming FIFO |
| ba_empty | input | 1 | Incoming FIFO is empty |
| byp_in | input | 18 | Bypass word arriving from the far side |
| byp_out | output | 18 | Bypass word sent to the far side |
| thr_ab_ae | output | 9 | Outgoing FIFO almost-empty threshold |
| thr_ab_af | output | 9 | Outgoing FIFO almost-full threshold |
| thr_ba_ae | output | 9 | Incoming FIFO almost-empty threshold |
| thr_ba_af | output | 9 | Incoming FIFO almost-full threshold |

## Verification
The output enable and a read access are two functions that can fall in the same cycle. `dq_oe` follows `oe_n` combinationally, while the output register updates only on an enabled edge. The sweep therefore holds `oe_n` low across reads that are blocked by `en_n`, by `ba_empty` or by a reserved address. In each such cycle the bench expects `dq_oe` high while `dq_out` keeps its value or clears, as its own model predicts.

A second same-cycle pair is a FIFO strobe and the full or empty status. Every address, direction and enable pattern is driven with the status both set and clear. The strobes are judged before the edge, and the registered word is judged after it.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int ADDR_W  = 3;
  localparam int N_THR   = 4;
  localparam int THR_IDX = $clog2(N_THR);

  typedef enum logic [1:0] {
    RES_FIFO = 2'd0,
    RES_BYP  = 2'd1,
    RES_RSV  = 2'd2,
    RES_THR  = 2'd3
  } res_e;

  function automatic res_e res_of(input logic [ADDR_W-1:0] a);
    if (a[2])            return RES_THR;
    else if (a[1])       return RES_RSV;
    else if (a[0])       return RES_BYP;
    else                 return RES_FIFO;
  endfunction

  function automatic logic [THR_IDX-1:0] thr_slot(input logic [ADDR_W-1:0] a);
    return a[THR_IDX-1:0];
  endfunction
endpackage

// File: rtl/prd_decode.sv
module prd_decode
  import prd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_wr_n,
  input  logic              en_n,
  input  logic              ab_full,
  input  logic              ba_empty,
  output logic              ab_wr,
  output logic              ba_rd,
  output logic              byp_ld,
  output logic [N_THR-1:0]  thr_ld,
  output logic              rsv_rd,
  output logic              out_ld,
  output res_e              rd_res
);
  logic acc_wr, acc_rd, any_ld;
  res_e res;

  always_comb begin
    res    = res_of(addr);
    acc_wr = !sel_n && !en_n && !rd_wr_n;
    acc_rd = !sel_n && !en_n &&  rd_wr_n;
    ab_wr  = acc_wr && (res == RES_FIFO) && !ab_full;
    ba_rd  = acc_rd && (res == RES_FIFO) && !ba_empty;
    byp_ld = acc_wr && (res == RES_BYP);
    rsv_rd = acc_rd && (res == RES_RSV);
    thr_ld = '0;
    if (acc_wr && res == RES_THR) thr_ld[thr_slot(addr)] = 1'b1;
    out_ld = ba_rd || (acc_rd && res != RES_FIFO);
    rd_res = res;
  end

  assign any_ld = ab_wr | ba_rd | byp_ld | out_ld | (|thr_ld);

  AST_SEL_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) sel_n |-> !any_ld); // R1
  AST_EN_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) en_n |-> !any_ld); // R9
  AST_FULL_BLOCK:  assert property (@(posedge clk) disable iff (!rst_n) ab_full |-> !ab_wr); // R4
  AST_EMPTY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) ba_empty |-> !ba_rd); // R4
  AST_ONE_THR:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(thr_ld)); // R6
endmodule

// File: rtl/prd_thr_bank.sv
module prd_thr_bank
  import prd_pkg::*;
#(
  parameter int OFS_W   = 9,
  parameter int OFS_RST = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_THR-1:0]         thr_ld,
  input  logic [OFS_W-1:0]         wdata,
  input  logic [THR_IDX-1:0]       rd_slot,
  output logic [N_THR-1:0][OFS_W-1:0] thr_q,
  output logic [OFS_W-1:0]         rd_val
);
  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)         thr_q[g] <= OFS_W'(OFS_RST);
      else if (thr_ld[g]) thr_q[g] <= wdata;
    end
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_ld[g] |=> $stable(thr_q[g])); // R6
  end

  assign rd_val = thr_q[rd_slot];
endmodule

// File: rtl/prd_rd_reg.sv
module prd_rd_reg
  import prd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_ld,
  input  logic              rsv_rd,
  input  res_e              rd_res,
  input  logic [DATA_W-1:0] fifo_word,
  input  logic [DATA_W-1:0] byp_word,
  input  logic [OFS_W-1:0]  thr_word,
  output logic [DATA_W-1:0] q
);
  localparam int PAD_W = DATA_W - OFS_W;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (rd_res)
      RES_FIFO: nxt = fifo_word;
      RES_BYP:  nxt = byp_word;
      RES_THR:  nxt = {{PAD_W{1'b0}}, thr_word};
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (out_ld) q <= nxt;
  end

  AST_RSV_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) rsv_rd |=> (q == '0)); // R8
  AST_OUT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !out_ld |=> $stable(q)); // R4
endmodule

// File: rtl/port_res_decoder.sv
module port_res_decoder
  import prd_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFS_W   = 9,
  parameter int OFS_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [2:0]        addr,
  input  logic              rd_wr_n,
  input  logic              en_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ab_wr,
  output logic [DATA_W-1:0] ab_wdata,
  input  logic              ab_full,
  output logic              ba_rd,
  input  logic [DATA_W-1:0] ba_rdata,
  input  logic              ba_empty,
  input  logic [DATA_W-1:0] byp_in,
  output logic [DATA_W-1:0] byp_out,
  output logic [OFS_W-1:0]  thr_ab_ae,
  output logic [OFS_W-1:0]  thr_ab_af,
  output logic [OFS_W-1:0]  thr_ba_ae,
  output logic [OFS_W-1:0]  thr_ba_af
);
  logic                        byp_ld, rsv_rd, out_ld;
  logic [N_THR-1:0]            thr_ld;
  logic [N_THR-1:0][OFS_W-1:0] thr_q;
  logic [OFS_W-1:0]            thr_rd;
  res_e                        rd_res;

  prd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .rd_wr_n(rd_wr_n),
    .en_n(en_n), .ab_full(ab_full), .ba_empty(ba_empty), .ab_wr(ab_wr),
    .ba_rd(ba_rd), .byp_ld(byp_ld), .thr_ld(thr_ld), .rsv_rd(rsv_rd),
    .out_ld(out_ld), .rd_res(rd_res)
  );

  prd_thr_bank #(.OFS_W(OFS_W), .OFS_RST(OFS_RST)) u_thr (
    .clk(clk), .rst_n(rst_n), .thr_ld(thr_ld), .wdata(dq_in[OFS_W-1:0]),
    .rd_slot(thr_slot(addr)), .thr_q(thr_q), .rd_val(thr_rd)
  );

  prd_rd_reg #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .out_ld(out_ld), .rsv_rd(rsv_rd), .rd_res(rd_res),
    .fifo_word(ba_rdata), .byp_word(byp_in), .thr_word(thr_rd), .q(dq_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      byp_out <= '0;
    else if (byp_ld) byp_out <= dq_in;
  end

  assign ab_wdata  = dq_in;
  assign dq_oe     = !sel_n && rd_wr_n && !oe_n;
  assign thr_ab_ae = thr_q[0];
  assign thr_ab_af = thr_q[1];
  assign thr_ba_ae = thr_q[2];
  assign thr_ba_af = thr_q[3];

  AST_OE_READ:  assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (rd_wr_n && !sel_n)); // R10
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !byp_ld |=> $stable(byp_out)); // R5
  AST_WR_DIR:   assert property (@(posedge clk) disable iff (!rst_n) ab_wr |-> (!rd_wr_n && !ba_rd)); // R2
endmodule

// File: tb/test_port_res_decoder.sv
module test_port_res_decoder;
  localparam int DW = 18;
  localparam int OW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, rd_wr_n = 1'b1, en_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = '0;
  logic [DW-1:0] dq_in = '0, ba_rdata = '0, byp_in = '0;
  logic ab_full = 1'b0, ba_empty = 1'b0;
  logic [DW-1:0] dq_out, ab_wdata, byp_out;
  logic dq_oe, ab_wr, ba_rd;
  logic [OW-1:0] thr_ab_ae, thr_ab_af, thr_ba_ae, thr_ba_af;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_out, m_byp;
  logic [OW-1:0] m_thr [4];

  always #10 clk = ~clk;

  port_res_decoder i_port_res_decoder (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .rd_wr_n(rd_wr_n),
    .en_n(en_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .ab_wr(ab_wr), .ab_wdata(ab_wdata), .ab_full(ab_full), .ba_rd(ba_rd),
    .ba_rdata(ba_rdata), .ba_empty(ba_empty), .byp_in(byp_in), .byp_out(byp_out),
    .thr_ab_ae(thr_ab_ae), .thr_ab_af(thr_ab_af), .thr_ba_ae(thr_ba_ae),
    .thr_ba_af(thr_ba_af)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(input bit s, input bit e, input bit blk, input string base);
    if (s) return "R1";
    if (e) return "R9";
    if (blk) return "R4";
    return base;
  endfunction

  task automatic chk_regs(input string req);
    chk({req, " dq_out"}, 32'(dq_out), 32'(m_out));
    chk({req, " byp_out"}, 32'(byp_out), 32'(m_byp));
    chk({req, " thr0"}, 32'(thr_ab_ae), 32'(m_thr[0]));
    chk({req, " thr1"}, 32'(thr_ab_af), 32'(m_thr[1]));
    chk({req, " thr2"}, 32'(thr_ba_ae), 32'(m_thr[2]));
    chk({req, " thr3"}, 32'(thr_ba_af), 32'(m_thr[3]));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    k = 0;
    m_out = '0; m_byp = '0;
    for (int i = 0; i < 4; i++) m_thr[i] = 9'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk_regs("R7 reset");
    chk("R1 oe idle", 32'(dq_oe), 32'd0);

    for (int pass = 0; pass < 2; pass++)
    for (int s = 0; s < 2; s++)
    for (int a = 0; a < 8; a++)
    for (int rw = 0; rw < 2; rw++)
    for (int e = 0; e < 2; e++)
    for (int fl = 0; fl < 2; fl++)
    for (int o = 0; o < 2; o++) begin
      bit act, blk;
      string base;
      k++;
      sel_n = s[0]; addr = a[2:0]; rd_wr_n = rw[0]; en_n = e[0];
      ab_full = fl[0]; ba_empty = fl[0]; oe_n = o[0];
      dq_in    = DW'((k * 32'd40503) ^ 32'h2B5A7);
      ba_rdata = DW'((k * 32'd7919)  ^ 32'h15C3A);
      byp_in   = DW'((k * 32'd2749)  ^ 32'h3A0F1);
      act = !s[0] && !e[0];
      blk = (a == 0) && fl[0];
      base = (a == 0) ? (rw[0] ? "R3" : "R2") : (a == 1) ? "R5" : (a < 4) ? "R8" : "R6";
      #5;
      chk({tag(s[0], e[0], blk, "R2"), " ab_wr"}, 32'(ab_wr),
          32'(act && !rw[0] && a == 0 && !fl[0]));
      if (ab_wr) chk("R2 ab_wdata", 32'(ab_wdata), 32'(dq_in));
      chk({tag(s[0], e[0], blk, "R3"), " ba_rd"}, 32'(ba_rd),
          32'(act && rw[0] && a == 0 && !fl[0]));
      chk("R10 dq_oe", 32'(dq_oe), 32'(!s[0] && rw[0] && !o[0]));
      if (act && !rw[0]) begin
        if (a == 1) m_byp = dq_in;
        else if (a >= 4) m_thr[a-4] = dq_in[OW-1:0];
      end else if (act && rw[0]) begin
        if (a == 0) begin if (!fl[0]) m_out = ba_rdata; end
        else if (a == 1) m_out = byp_in;
        else if (a < 4) m_out = '0;
        else m_out = DW'(m_thr[a-4]);
      end
      @(negedge clk); #2;
      chk_regs(tag(s[0], e[0], blk && rw[0], base));
      #1;
    end

    rst_n = 1'b0;
    @(negedge clk); #2;
    rst_n = 1'b1;
    m_out = '0; m_byp = '0;
    for (int i = 0; i < 4; i++) m_thr[i] = 9'd8;
    chk_regs("R7 re-reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule